// File: doc/BRIEF.md
# Mouse Motion Packet Encoder

This block turns one pointer event into the five bytes a classic serial mouse sends. An event carries a signed horizontal delta, a signed vertical delta and the state of three buttons. The encoder takes the event through a valid/ready pair, registers it, and then presents the packet one byte at a time on a valid/ready byte stream that feeds a serializer or a FIFO downstream.

The first byte is a sync byte whose low three bits are the buttons in active-low form. The two motion bytes are limited to the symmetric range -127 to +127. The vertical axis is inverted before limiting, because screen coordinates grow downward. Two zero bytes fill the packet out to its fixed length of five. The block accepts no new event until the last byte of the current packet has been taken.

Top module: `mouse_pkt_enc`

## Requirements
- R1: While `rst_ni` is low and after it is released, `byte_valid_o` is 0 and `evt_ready_o` is 1.
- R2: Byte 0 of a packet is 0x87 with bit 2 cleared if `evt_btn_i[2]` (left) was 1, bit 1 cleared if `evt_btn_i[1]` (middle) was 1, and bit 0 cleared if `evt_btn_i[0]` (right) was 1.
- R3: Byte 1 is the horizontal delta in two's complement, limited to +127 (0x7F) above and -127 (0x81) below.
- R4: Byte 2 is the negated vertical delta limited the same way. The most negative input value negates to +127 and does not wrap.
- R5: Bytes 3 and 4 are always 0x00.
- R6: The cycle after an event is accepted, `byte_valid_o` rises with byte 0. Bytes follow in the order 0 to 4, one per accepted handshake, and `byte_valid_o` falls the cycle after byte 4 is taken.
- R7: `evt_ready_o` is 0 for as long as a packet is being sent. An event that is offered meanwhile is neither taken nor allowed to change the packet in flight.
- R8: The event fields are captured when the event is accepted. Later changes on `evt_dx_i`, `evt_dy_i` and `evt_btn_i` do not alter the packet.
- R9: While `byte_valid_o` is 1 and `byte_ready_i` is 0, the next cycle keeps `byte_valid_o` at 1 and `byte_data_o` unchanged.
- R10: `evt_ready_o` returns to 1 the cycle after byte 4 is taken, so packets can run back to back with one idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | Encoder idle, event will be taken |
| evt_dx_i | input | DELTA_W | Signed horizontal delta |
| evt_dy_i | input | DELTA_W | Signed vertical delta |
| evt_btn_i | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| byte_valid_o | output | 1 | Packet byte present |
| byte_ready_i | input | 1 | Downstream takes the byte |
| byte_data_o | output | 8 | Packet byte |

## Verification
The bench uses the default delta width of 16 bits. At this width the inputs -32768 and +32767 drive both limiters into their extremes, and negating -32768 needs the extra bit. Directed events cover values just inside and just outside the ±127 window on both axes, every button combination, and an event held on the input during a packet. Random events then run with random back-pressure. A behavioural queue model predicts every output on every clock.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int BYTE_W    = 8;
  localparam int PKT_BYTES = 5;
  localparam int MAG_LIM   = 127;

  typedef logic [BYTE_W-1:0] pkt_byte_t;

  typedef struct packed {
    logic left;
    logic mid;
    logic right;
  } btn_t;

  // Sync byte: fixed high bit, buttons active low in bits 2:0.
  function automatic pkt_byte_t sync_byte(btn_t b);
    return {5'b10000, ~b.left, ~b.mid, ~b.right};
  endfunction
endpackage

// File: rtl/mpe_sat.sv
module mpe_sat
  import mpe_pkg::*;
#(
  parameter int IN_W = 17
) (
  input  logic signed [IN_W-1:0] val_i,
  output pkt_byte_t              sat_o
);
  localparam logic signed [IN_W-1:0] HI = IN_W'(MAG_LIM);
  localparam logic signed [IN_W-1:0] LO = -HI;

  always_comb begin
    if (val_i > HI)      sat_o = HI[BYTE_W-1:0];
    else if (val_i < LO) sat_o = LO[BYTE_W-1:0];
    else                 sat_o = val_i[BYTE_W-1:0];
  end
endmodule

// File: rtl/mpe_seq.sv
module mpe_seq #(
  parameter int N_BYTES = 5,
  localparam int IDX_W  = $clog2(N_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             take_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        idx_o  <= '0;
      end
    end else if (take_i) begin
      if (idx_o == LAST) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  output logic               evt_ready_o,
  input  logic [DELTA_W-1:0] evt_dx_i,
  input  logic [DELTA_W-1:0] evt_dy_i,
  input  logic [2:0]         evt_btn_i,
  output logic               byte_valid_o,
  input  logic               byte_ready_i,
  output logic [7:0]         byte_data_o
);
  localparam int EXT_W = DELTA_W + 1;
  localparam int IDX_W = $clog2(PKT_BYTES);

  logic               busy;
  logic [IDX_W-1:0]   idx;
  logic               accept;
  logic [DELTA_W-1:0] dx_q, dy_q;
  btn_t               btn_q;
  logic signed [EXT_W-1:0] x_ext, y_neg;
  pkt_byte_t          pkt [PKT_BYTES];

  assign evt_ready_o  = ~busy;
  assign accept       = evt_valid_i & ~busy;
  assign byte_valid_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dx_q  <= '0;
      dy_q  <= '0;
      btn_q <= '0;
    end else if (accept) begin
      dx_q  <= evt_dx_i;
      dy_q  <= evt_dy_i;
      btn_q <= btn_t'(evt_btn_i);
    end
  end

  mpe_seq #(.N_BYTES(PKT_BYTES)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .take_i (byte_ready_i),
    .busy_o (busy),
    .idx_o  (idx)
  );

  // One extra bit so that negating the most negative value cannot wrap.
  assign x_ext = $signed({dx_q[DELTA_W-1], dx_q});
  assign y_neg = -$signed({dy_q[DELTA_W-1], dy_q});

  assign pkt[0] = sync_byte(btn_q);

  mpe_sat #(.IN_W(EXT_W)) u_sat_x (.val_i(x_ext), .sat_o(pkt[1]));
  mpe_sat #(.IN_W(EXT_W)) u_sat_y (.val_i(y_neg), .sat_o(pkt[2]));

  for (genvar g = 3; g < PKT_BYTES; g++) begin : g_pad
    assign pkt[g] = '0;
  end

  assign byte_data_o = pkt[idx];
endmodule

// File: rtl/mpe_chk.sv
module mpe_chk #(
  parameter int N_BYTES = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_valid_i,
  input logic       evt_ready_o,
  input logic       byte_valid_o,
  input logic       byte_ready_i,
  input logic [7:0] byte_data_o
);
  logic [3:0] pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos <= '0;
    else if (byte_valid_o && byte_ready_i)
      pos <= (pos == 4'(N_BYTES - 1)) ? '0 : pos + 1'b1;
  end

  p_start_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && evt_ready_o |=> byte_valid_o && byte_data_o[7:3] == 5'b10000);

  p_sync_form_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && pos == 4'd0 |-> byte_data_o[7:3] == 5'b10000);

  p_no_minus128_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && (pos == 4'd1 || pos == 4'd2) |-> byte_data_o != 8'h80);

  p_pad_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && pos >= 4'd3 |-> byte_data_o == 8'h00);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_data_o));

  p_ready_after_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o && byte_ready_i && pos == 4'(N_BYTES - 1) |=> evt_ready_o && !byte_valid_o);
endmodule

bind mouse_pkt_enc mpe_chk #(.N_BYTES(mpe_pkg::PKT_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .evt_ready_o (evt_ready_o),
  .byte_valid_o(byte_valid_o),
  .byte_ready_i(byte_ready_i),
  .byte_data_o (byte_data_o)
);

// File: tb/mouse_pkt_enc_test.sv
`timescale 1ns/1ps
module mouse_pkt_enc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [15:0] evt_dx = '0, evt_dy = '0;
  logic [2:0]  evt_btn = '0;
  logic        byte_ready = 1'b1;
  logic        evt_ready, byte_valid;
  logic [7:0]  byte_data;

  int   n_chk = 0, n_err = 0;
  bit   acc_flag = 0, stall = 0, done = 0;
  bit   stall_prev = 0;
  logic [7:0] prev_data = '0;
  int   pos = 0;
  logic [7:0] q[$];

  always #4 clk = ~clk;

  mouse_pkt_enc uut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_valid), .evt_ready_o(evt_ready),
    .evt_dx_i(evt_dx), .evt_dy_i(evt_dy), .evt_btn_i(evt_btn),
    .byte_valid_o(byte_valid), .byte_ready_i(byte_ready), .byte_data_o(byte_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] clamp(int v);
    if (v > 127)  return 8'h7f;
    if (v < -127) return 8'h81;
    return v[7:0];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Reference model, evaluated between edges.
  always @(negedge clk) if (rst_n && !done) begin
    bit ev;
    ev = q.size() > 0;
    chk(byte_valid === ev, "R6 valid", {7'd0, byte_valid}, {7'd0, ev});
    chk(evt_ready === !ev, "R7 R10 evt_ready", {7'd0, evt_ready}, {7'd0, !ev});
    if (ev) begin
      case (pos)
        0:       chk(byte_data === q[0], "R2 sync byte", byte_data, q[0]);
        1:       chk(byte_data === q[0], "R3 x byte", byte_data, q[0]);
        2:       chk(byte_data === q[0], "R4 y byte", byte_data, q[0]);
        default: chk(byte_data === q[0], "R5 pad byte", byte_data, q[0]);
      endcase
    end
    if (stall_prev)
      chk(byte_valid === 1'b1 && byte_data === prev_data, "R9 hold", byte_data, prev_data);
    stall_prev = byte_valid && !byte_ready;
    prev_data  = byte_data;
    if (ev && byte_ready) begin
      void'(q.pop_front());
      pos = (pos + 1) % 5;
    end else if (!ev && evt_valid) begin
      logic [7:0] b0;
      b0 = 8'h87;
      if (evt_btn[2]) b0[2] = 1'b0;
      if (evt_btn[1]) b0[1] = 1'b0;
      if (evt_btn[0]) b0[0] = 1'b0;
      q.push_back(b0);
      q.push_back(clamp(int'($signed(evt_dx))));
      q.push_back(clamp(-int'($signed(evt_dy))));
      q.push_back(8'h00);
      q.push_back(8'h00);
      pos = 0;
      acc_flag = 1;
    end
  end

  always @(posedge clk) begin
    #1;
    byte_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic send(input int dx, input int dy, input logic [2:0] btn, input bit hold_busy);
    evt_dx = dx[15:0];
    evt_dy = dy[15:0];
    evt_btn = btn;
    evt_valid = 1'b1;
    do @(posedge clk); while (!acc_flag);
    acc_flag = 0;
    #1;
    // R8: scramble fields after capture; R7: optionally keep offering during the packet.
    evt_dx = 16'h5a5a ^ dx[15:0];
    evt_dy = 16'ha5a5 ^ dy[15:0];
    evt_btn = ~btn;
    evt_valid = hold_busy;
    if (hold_busy) begin
      repeat (2) @(posedge clk);
      #1 evt_valid = 1'b0;
    end
  endtask

  initial begin
    #1 chk(byte_valid === 1'b0 && evt_ready === 1'b1, "R1 reset", {6'd0, byte_valid, evt_ready}, 8'h01);
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk(byte_valid === 1'b0 && evt_ready === 1'b1, "R1 after reset", {6'd0, byte_valid, evt_ready}, 8'h01);
    @(posedge clk); #1;
    send(0, 0, 3'b000, 0);
    send(5, -3, 3'b100, 0);
    send(200, -200, 3'b010, 1);
    send(-200, 200, 3'b001, 0);
    send(-32768, -32768, 3'b111, 0);
    send(32767, 32767, 3'b011, 1);
    send(127, -127, 3'b101, 0);
    send(-127, 127, 3'b110, 0);
    send(128, -128, 3'b000, 0);
    send(-128, 128, 3'b111, 0);
    stall = 1;
    for (int i = 0; i < 200; i++) begin
      int rx, ry;
      rx = int'($signed(16'($urandom)));
      ry = (i % 4 == 0) ? int'($signed(16'($urandom_range(0, 511)))) - 256
                        : int'($signed(16'($urandom)));
      send(rx, ry, 3'($urandom), (i % 7) == 0);
    end
    send(-32768, 32767, 3'b010, 1);
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end
endmodule